// File: doc/BRIEF.md
# Transient Reversal Trip Blocker

This block holds back the trip output of a protection scheme while power reversals follow the clearing of a fault outside the protected zone. It watches two inputs. One is a high-set fault-detector flag. The other is the output of the trip integrator. When a fault is present but the integrator has not fired, the block is armed. If it stays armed for a programmable pickup time, the block starts to veto the trip path. The veto then lasts for a programmable dropout time after the arming condition goes away.

On a fault inside the zone, the integrator fires before the pickup time runs out, so the trip passes with no added delay. For that reason the pickup setting must be longer than the usual time from fault detection to integrator output. Both delays are counted in whole milliseconds from a one-cycle tick. The trip path itself is combinational: the gated trip equals the raw request unless blocking is active.

The control is a four-state machine:
- `ST_IDLE`: disarmed.
- `ST_ARMING`: the pickup count is running.
- `ST_BLOCKED`: armed and vetoing.
- `ST_HOLD`: disarmed, still vetoing, and the dropout count is running.

Its transitions are:
- idle-to-arming: armed, with a non-zero pickup setting.
- idle-to-blocked: armed, with a zero pickup setting.
- arming-to-idle: disarmed early.
- arming-to-blocked: the pickup count expires.
- blocked-to-hold: disarmed, with a non-zero dropout setting.
- blocked-to-idle: disarmed, with a zero dropout setting.
- hold-to-blocked: re-armed.
- hold-to-idle: the dropout count expires.

Top module: `trb_blocker`

## Requirements
- R1: The block is armed only while `fault_hi` is 1 and `integ_out` is 0. While it is disarmed and not already blocking, `block_active` stays 0 however many ticks arrive.
- R2: With a pickup setting P > 0, `block_active` rises on the clock edge that samples the P-th `tick_ms` pulse of an unbroken armed interval, and not before.
- R3: `trip_out` equals `trip_req` in the same cycle while `block_active` is 0, and is 0 while `block_active` is 1.
- R4: With a dropout setting D > 0, `block_active` stays 1 after disarming until the edge that samples the D-th tick counted since disarming. Disarming may come from `fault_hi` falling or from `integ_out` rising.
- R5: If the block is disarmed before the pickup count completes, the count is discarded. A later armed interval needs a full P ticks of its own.
- R6: Re-arming during the dropout interval returns the block to steady blocking. The next disarm starts a fresh dropout count of D ticks.
- R7: A pickup setting of 0 raises `block_active` one clock after arming. A dropout setting of 0 clears it one clock after disarming.
- R8: A synchronous active-high `rst` returns the block to idle with `block_active` at 0, whatever state it was in.
- R9: When pickup and dropout are both non-zero, `block_active` does not change on an edge where `tick_ms` is 0 (reset aside).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| fault_hi | input | 1 | High-set fault detector picked up |
| integ_out | input | 1 | Trip integrator output asserted |
| trip_req | input | 1 | Raw trip request from the comparison logic |
| pickup_ms | input | 10 | Pickup delay in ms (0 to 999) |
| dropout_ms | input | 10 | Dropout delay in ms (0 to 999) |
| trip_out | output | 1 | Gated trip output |
| block_active | output | 1 | Trip blocking in force |

## Verification
Some rules are checked by the assertions on every cycle:
- A trip never passes while blocking is active.
- Blocking starts only while armed, and ends only while disarmed.
- A start with a non-zero pickup setting follows a tick.
- Blocking never changes on a cycle without a tick.
- Reset leaves blocking off.

Exact tick counts can only be shown by the bench's scenarios. These are the P-th tick that raises blocking, the D-th tick that releases it, the discarded partial pickup, and the restart of the dropout count on re-arm. The bench also covers the internal fault, where the integrator fires early and the trip passes untouched.

// File: rtl/trb_pkg.sv
package trb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMING  = 2'd1,
        ST_BLOCKED = 2'd2,
        ST_HOLD    = 2'd3
    } trb_state_e;
endpackage

// File: rtl/trb_arm_detect.sv
module trb_arm_detect (
    input  logic fault_hi,
    input  logic integ_out,
    output logic arm
);
    // Fault seen but the integrator has not produced a trip.
    always_comb arm = fault_hi & ~integ_out;
endmodule

// File: rtl/trb_tick_counter.sv
module trb_tick_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        expired  = run & tick & (cnt_next >= {1'b0, limit});
    end

    // Counter is held at zero whenever the state machine is not timing.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != CNT_MAX) begin
            cnt <= cnt_next[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/trb_fsm.sv
module trb_fsm
    import trb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic pick_zero,
    input  logic drop_zero,
    input  logic expired,
    output logic run,
    output logic pick_phase,
    output logic block
);
    trb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (arm) state_nx = pick_zero ? ST_BLOCKED : ST_ARMING;
            end
            ST_ARMING: begin
                if (!arm)         state_nx = ST_IDLE;
                else if (expired) state_nx = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (!arm) state_nx = drop_zero ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (arm)          state_nx = ST_BLOCKED;
                else if (expired) state_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        run        = 1'b0;
        pick_phase = 1'b0;
        block      = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ARMING:  begin run = arm;  pick_phase = 1'b1; end
            ST_BLOCKED: block = 1'b1;
            ST_HOLD:    begin run = ~arm; block = 1'b1; end
        endcase
    end
endmodule

// File: rtl/trb_blocker.sv
module trb_blocker #(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             fault_hi,
    input  logic             integ_out,
    input  logic             trip_req,
    input  logic [DLY_W-1:0] pickup_ms,
    input  logic [DLY_W-1:0] dropout_ms,
    output logic             trip_out,
    output logic             block_active
);
    logic arm, run, pick_phase, expired;
    logic [DLY_W-1:0] limit;

    trb_arm_detect u_arm (
        .fault_hi  (fault_hi),
        .integ_out (integ_out),
        .arm       (arm)
    );

    // One counter serves both phases; the state picks which limit applies.
    always_comb limit = pick_phase ? pickup_ms : dropout_ms;

    trb_tick_counter #(.CNT_W(DLY_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick_ms),
        .limit   (limit),
        .expired (expired)
    );

    trb_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .pick_zero  (pickup_ms == '0),
        .drop_zero  (dropout_ms == '0),
        .expired    (expired),
        .run        (run),
        .pick_phase (pick_phase),
        .block      (block_active)
    );

    always_comb trip_out = trip_req & ~block_active;
endmodule

// File: rtl/trb_blocker_chk.sv
module trb_blocker_chk #(
    parameter int DLY_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_ms,
    input logic             fault_hi,
    input logic             integ_out,
    input logic             trip_req,
    input logic [DLY_W-1:0] pickup_ms,
    input logic [DLY_W-1:0] dropout_ms,
    input logic             trip_out,
    input logic             block_active
);
    // R1
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!block_active && !(fault_hi && !integ_out)) |=> !block_active);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(block_active) && $past(!rst) && $past(pickup_ms != '0)) |-> $past(tick_ms));

    // R2
    start_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(block_active) && $past(!rst)) |-> $past(fault_hi && !integ_out));

    // R3
    veto_chk: assert property (@(posedge clk) disable iff (rst)
        block_active |-> !trip_out);

    // R3
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!block_active && trip_req) |-> trip_out);

    // R4
    release_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(block_active) && $past(!rst)) |-> $past(!(fault_hi && !integ_out)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !block_active);

    // R9
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_ms && pickup_ms != '0 && dropout_ms != '0) |=> $stable(block_active));
endmodule

bind trb_blocker trb_blocker_chk #(.DLY_W(DLY_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .tick_ms      (tick_ms),
    .fault_hi     (fault_hi),
    .integ_out    (integ_out),
    .trip_req     (trip_req),
    .pickup_ms    (pickup_ms),
    .dropout_ms   (dropout_ms),
    .trip_out     (trip_out),
    .block_active (block_active)
);

// File: tb/trb_blocker_test.sv
`timescale 1ns/1ps
module trb_blocker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b0;
    logic       fault_hi = 1'b0;
    logic       integ_out = 1'b0;
    logic       trip_req = 1'b0;
    logic [9:0] pickup_ms = 10'd5;
    logic [9:0] dropout_ms = 10'd4;
    logic       trip_out, block_active;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trb_blocker uut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .fault_hi(fault_hi),
        .integ_out(integ_out), .trip_req(trip_req), .pickup_ms(pickup_ms),
        .dropout_ms(dropout_ms), .trip_out(trip_out), .block_active(block_active)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        fault_hi = 1'b0; integ_out = 1'b0; trip_req = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        check("R8 reset state", block_active, 1'b0);
        trip_req = 1'b1; #1;
        check("R3 trip passes after reset", trip_out, 1'b1);
        trip_req = 1'b0;
    endtask

    task automatic t_internal();
        fault_hi = 1'b1; step(2);
        ticks(2);
        integ_out = 1'b1; trip_req = 1'b1; #1;
        check("R3 internal fault trip passes", trip_out, 1'b1);
        ticks(10);
        check("R1 integrator high stops arming", block_active, 1'b0);
        check("R3 trip still passes", trip_out, 1'b1);
        quiet();
    endtask

    task automatic t_external();
        fault_hi = 1'b1; step(2);
        ticks(4);
        check("R2 no block before P ticks", block_active, 1'b0);
        trip_req = 1'b1; #1;
        check("R3 trip passes before pickup", trip_out, 1'b1);
        ticks(1);
        check("R2 block at P-th tick", block_active, 1'b1);
        check("R3 trip vetoed", trip_out, 1'b0);
        fault_hi = 1'b0; step(2);
        ticks(3);
        check("R4 block held in dropout", block_active, 1'b1);
        check("R3 trip still vetoed in dropout", trip_out, 1'b0);
        ticks(1);
        check("R4 release at D-th tick", block_active, 1'b0);
        check("R3 trip passes after release", trip_out, 1'b1);
        quiet();
    endtask

    task automatic t_early_drop();
        fault_hi = 1'b1; step(2);
        ticks(3);
        fault_hi = 1'b0; step(2);
        fault_hi = 1'b1; step(2);
        ticks(4);
        check("R5 partial count discarded", block_active, 1'b0);
        ticks(1);
        check("R5 full P ticks needed", block_active, 1'b1);
        quiet();
    endtask

    task automatic t_rearm();
        fault_hi = 1'b1; step(2);
        ticks(5);
        check("R6 blocked before rearm test", block_active, 1'b1);
        integ_out = 1'b1; step(2);
        ticks(2);
        integ_out = 1'b0; step(2);
        integ_out = 1'b1; step(2);
        ticks(3);
        check("R6 dropout restarted", block_active, 1'b1);
        ticks(1);
        check("R4 release after integrator disarm", block_active, 1'b0);
        quiet();
    endtask

    task automatic t_zero();
        pickup_ms = 10'd0; dropout_ms = 10'd0;
        fault_hi = 1'b1; step(1);
        check("R7 zero pickup blocks next clock", block_active, 1'b1);
        fault_hi = 1'b0; step(1);
        check("R7 zero dropout clears next clock", block_active, 1'b0);
        pickup_ms = 10'd5; dropout_ms = 10'd4;
        quiet();
    endtask

    task automatic t_notick();
        fault_hi = 1'b1; step(30);
        check("R9 no progress without tick (pickup)", block_active, 1'b0);
        ticks(5);
        fault_hi = 1'b0; step(30);
        check("R9 no progress without tick (dropout)", block_active, 1'b1);
        ticks(4);
        check("R4 release after ticks", block_active, 1'b0);
        quiet();
    endtask

    task automatic t_reset_mid();
        fault_hi = 1'b1; step(2);
        ticks(5);
        check("R8 blocked before reset", block_active, 1'b1);
        rst = 1'b1; step(1);
        check("R8 reset clears block", block_active, 1'b0);
        quiet();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_internal();
        t_external();
        t_early_drop();
        t_rearm();
        t_zero();
        t_notick();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule